// File: doc/BRIEF.md
# Global Interrupt Summary and Enable Register

This block is one 16-bit control and status word inside a communication controller. It reports eight interrupt lines, each with a flag bit and an enable bit. For five of the lines the flag is a summary: it is set whenever any source in a bank of individual flags is set together with that source's own enable. Those banks live outside the block and arrive as input vectors. The other three lines have flags that the block latches itself. A one-cycle event pulse sets such a flag, and software clears it by writing a one to its bit.

Software reaches the word through a simple single-address register port. The block also drives one registered interrupt request per line, each gated by the line's enable bit in this word.

Top module: `irq_summary_reg`

## Requirements
- R1: Bit i (i = 0..7) is the flag and bit 8+i is the enable of line i. The line order is: 0 message, 1 protocol, 2 CHI error, 3 wakeup, 4 FIFO-B, 5 FIFO-A, 6 receive buffer, 7 transmit buffer.
- R2: The flag of each summary line (0, 1, 2, 6, 7) reads as the OR, across its SRC_N sources, of each source flag ANDed with that source's enable. It is combinational from the inputs.
- R3: Summary flag bits are read-only. Writing them, with ones or zeros, has no effect.
- R4: An event flag (lines 3, 4, 5) clears on the clock edge of a write with a one in its bit. A write with a zero in its bit leaves the flag unchanged.
- R5: An event pulse sets its flag on the next edge. If the event and a software clear arrive in the same cycle, the flag stays set.
- R6: The eight enable bits are read/write. They take bus_wdata[15:8] on the edge of a write and hold their value otherwise.
- R7: irq_req[i] equals the line-i flag ANDed with the line-i enable, registered, so it appears one clock after the inputs that produce it.
- R8: The register sits at address REG_ADDR. bus_rdata shows the word only during a read (bus_sel=1, bus_wr=0) at that address and is zero otherwise. A write to any other address changes nothing.
- R9: A synchronous active-high reset clears all 16 bits and every interrupt request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Access address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, zero when not a read hit |
| msg_src_flag | input | SRC_N | Message source flags |
| msg_src_en | input | SRC_N | Message source enables |
| prot_src_flag | input | SRC_N | Protocol source flags |
| prot_src_en | input | SRC_N | Protocol source enables |
| chi_src_flag | input | SRC_N | CHI error source flags |
| chi_src_en | input | SRC_N | CHI error source enables |
| rxb_src_flag | input | SRC_N | Receive buffer source flags |
| rxb_src_en | input | SRC_N | Receive buffer source enables |
| txb_src_flag | input | SRC_N | Transmit buffer source flags |
| txb_src_en | input | SRC_N | Transmit buffer source enables |
| ev_wakeup | input | 1 | Wakeup event pulse |
| ev_fifo_b | input | 1 | FIFO-B event pulse |
| ev_fifo_a | input | 1 | FIFO-A event pulse |
| irq_req | output | 8 | Registered interrupt request per line |

## Verification
The bench tests masking at two levels. It sets source flags whose own enables are off, and a summary flag that lights must not raise its request while the line enable is clear; a design that dropped either AND would assert interrupts that nobody enabled. It walks a single set source across all four positions of each bank, so a reduction that looked at only part of the vector loses a position. It writes zeros and ones to the flag half of the word, and puts an event pulse in the same cycle as its clear: a design that cleared on a zero, accepted writes into summary bits, or let the clear win would lose or invent flags. Random traffic, including misaddressed writes, is compared against the reference model on every clock.

// File: rtl/irq_sum_pkg.sv
package irq_sum_pkg;
    localparam int NUM_LINES = 8;
    localparam int REG_W     = 2 * NUM_LINES;

    typedef enum logic [2:0] {
        LN_MSG   = 3'd0,
        LN_PROT  = 3'd1,
        LN_CHI   = 3'd2,
        LN_WKUP  = 3'd3,
        LN_FIFOB = 3'd4,
        LN_FIFOA = 3'd5,
        LN_RXB   = 3'd6,
        LN_TXB   = 3'd7
    } line_e;

    typedef struct packed {
        logic [NUM_LINES-1:0] en;
        logic [NUM_LINES-1:0] flag;
    } gword_t;

    // Lines whose flag is latched from an event and cleared by writing one.
    localparam logic [NUM_LINES-1:0] EVT_MASK = 8'b0011_1000;

    function automatic logic is_event_line(input int idx);
        return EVT_MASK[idx];
    endfunction
endpackage

// File: rtl/irq_or_reduce.sv
module irq_or_reduce #(
    parameter int N = 4
) (
    input  logic [N-1:0] src_flag,
    input  logic [N-1:0] src_en,
    output logic         summary
);
    logic [N-1:0] masked;

    for (genvar k = 0; k < N; k++) begin : g_mask
        assign masked[k] = src_flag[k] & src_en[k];
    end

    assign summary = |masked;
endmodule

// File: rtl/irq_evt_latch.sv
module irq_evt_latch (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic sw_clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)         flag <= 1'b0;
        else if (evt)    flag <= 1'b1;
        else if (sw_clr) flag <= 1'b0;
    end

    AST_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
        evt |=> flag); // R5
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (sw_clr && !evt) |=> !flag); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!sw_clr && !evt) |=> flag == $past(flag)); // R4
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] flag,
    input  logic [W-1:0] en,
    output logic [W-1:0] irq
);
    always_ff @(posedge clk) begin
        if (rst) irq <= '0;
        else     irq <= flag & en;
    end
endmodule

// File: rtl/irq_summary_reg.sv
module irq_summary_reg
    import irq_sum_pkg::*;
#(
    parameter int               SRC_N    = 4,
    parameter int               ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [REG_W-1:0]     bus_wdata,
    output logic [REG_W-1:0]     bus_rdata,
    input  logic [SRC_N-1:0]     msg_src_flag,
    input  logic [SRC_N-1:0]     msg_src_en,
    input  logic [SRC_N-1:0]     prot_src_flag,
    input  logic [SRC_N-1:0]     prot_src_en,
    input  logic [SRC_N-1:0]     chi_src_flag,
    input  logic [SRC_N-1:0]     chi_src_en,
    input  logic [SRC_N-1:0]     rxb_src_flag,
    input  logic [SRC_N-1:0]     rxb_src_en,
    input  logic [SRC_N-1:0]     txb_src_flag,
    input  logic [SRC_N-1:0]     txb_src_en,
    input  logic                 ev_wakeup,
    input  logic                 ev_fifo_b,
    input  logic                 ev_fifo_a,
    output logic [NUM_LINES-1:0] irq_req
);
    logic                 addr_hit, wr_hit, rd_hit;
    logic [NUM_LINES-1:0] en_q;
    logic [NUM_LINES-1:0] flag_vec;
    logic [NUM_LINES-1:0] clr_vec;
    gword_t               word;

    assign addr_hit = bus_sel && (bus_addr == REG_ADDR);
    assign wr_hit   = addr_hit && bus_wr;
    assign rd_hit   = addr_hit && !bus_wr;
    assign clr_vec  = {NUM_LINES{wr_hit}} & bus_wdata[NUM_LINES-1:0] & EVT_MASK;

    // Enable half of the word
    always_ff @(posedge clk) begin
        if (rst)         en_q <= '0;
        else if (wr_hit) en_q <= bus_wdata[REG_W-1:NUM_LINES];
    end

    // Per-line flag source
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        if (is_event_line(i)) begin : g_evt
            logic evt_in;
            if (i == int'(LN_WKUP)) begin : g_w
                assign evt_in = ev_wakeup;
            end else if (i == int'(LN_FIFOB)) begin : g_b
                assign evt_in = ev_fifo_b;
            end else begin : g_a
                assign evt_in = ev_fifo_a;
            end
            irq_evt_latch u_latch (
                .clk    (clk),
                .rst    (rst),
                .evt    (evt_in),
                .sw_clr (clr_vec[i]),
                .flag   (flag_vec[i])
            );
        end else begin : g_sum
            logic [SRC_N-1:0] sf, se;
            if (i == int'(LN_MSG)) begin : g_m
                assign sf = msg_src_flag;  assign se = msg_src_en;
            end else if (i == int'(LN_PROT)) begin : g_p
                assign sf = prot_src_flag; assign se = prot_src_en;
            end else if (i == int'(LN_CHI)) begin : g_c
                assign sf = chi_src_flag;  assign se = chi_src_en;
            end else if (i == int'(LN_RXB)) begin : g_r
                assign sf = rxb_src_flag;  assign se = rxb_src_en;
            end else begin : g_t
                assign sf = txb_src_flag;  assign se = txb_src_en;
            end
            irq_or_reduce #(.N(SRC_N)) u_red (
                .src_flag (sf),
                .src_en   (se),
                .summary  (flag_vec[i])
            );
        end
    end

    assign word.flag = flag_vec;
    assign word.en   = en_q;
    assign bus_rdata = rd_hit ? word : '0;

    irq_out_stage #(.W(NUM_LINES)) u_out (
        .clk  (clk),
        .rst  (rst),
        .flag (flag_vec),
        .en   (en_q),
        .irq  (irq_req)
    );

    AST_EN_STABLE: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> $stable(en_q)); // R6
    AST_EN_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> en_q == $past(bus_wdata[REG_W-1:NUM_LINES])); // R6
    AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> irq_req == ($past(flag_vec) & $past(en_q))); // R7
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_req & ~$past(en_q)) == '0); // R7
    AST_RD_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rd_hit |-> bus_rdata == '0); // R8
endmodule

// File: tb/test_irq_summary_reg.sv
module test_irq_summary_reg;
    localparam int CLK_PERIOD = 10;
    localparam int SRC_N = 4;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] RA = 8'h16;

    logic clk = 0, rst = 1;
    logic bus_sel = 0, bus_wr = 0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0, bus_rdata;
    logic [SRC_N-1:0] sf [5];
    logic [SRC_N-1:0] se [5];
    logic ev_w = 0, ev_b = 0, ev_a = 0;
    logic [7:0] irq_req;

    int compared = 0, mismatched = 0, cycles = 0;
    string cur_req = "R9";

    // reference state
    bit       m_en [8];
    bit       m_evf [8];
    bit [7:0] m_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_summary_reg #(.SRC_N(SRC_N), .ADDR_W(ADDR_W), .REG_ADDR(RA)) i_irq_summary_reg (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .msg_src_flag(sf[0]), .msg_src_en(se[0]),
        .prot_src_flag(sf[1]), .prot_src_en(se[1]),
        .chi_src_flag(sf[2]), .chi_src_en(se[2]),
        .rxb_src_flag(sf[3]), .rxb_src_en(se[3]),
        .txb_src_flag(sf[4]), .txb_src_en(se[4]),
        .ev_wakeup(ev_w), .ev_fifo_b(ev_b), .ev_fifo_a(ev_a),
        .irq_req(irq_req)
    );

    function automatic int bank_of(int line);
        case (line)
            0: return 0; 1: return 1; 2: return 2; 6: return 3; 7: return 4;
            default: return -1;
        endcase
    endfunction

    function automatic bit model_flag(int line);
        int b = bank_of(line);
        if (b < 0) return m_evf[line];
        for (int k = 0; k < SRC_N; k++)
            if (sf[b][k] && se[b][k]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp, string what);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Inputs already driven (after a negedge); compare, then advance model over the next edge.
    task automatic step();
        logic [15:0] exp_word;
        bit hit_rd, hit_wr, evt[8];
        #1;
        for (int i = 0; i < 8; i++) begin
            exp_word[i]   = model_flag(i);
            exp_word[8+i] = m_en[i];
        end
        hit_rd = bus_sel && !bus_wr && bus_addr == RA;
        hit_wr = bus_sel && bus_wr && bus_addr == RA;
        check(cur_req, bus_rdata, hit_rd ? exp_word : 16'h0, "rdata");
        check(cur_req, {8'h0, irq_req}, {8'h0, m_irq}, "irq_req");
        evt = '{default: 0};
        evt[3] = ev_w; evt[4] = ev_b; evt[5] = ev_a;
        for (int i = 0; i < 8; i++) m_irq[i] = exp_word[i] & m_en[i];
        for (int i = 3; i <= 5; i++)
            if (evt[i]) m_evf[i] = 1;
            else if (hit_wr && bus_wdata[i]) m_evf[i] = 0;
        if (hit_wr) for (int i = 0; i < 8; i++) m_en[i] = bus_wdata[8+i];
        @(posedge clk);
        @(negedge clk);
        cycles++;
    endtask

    task automatic idle();
        bus_sel = 0; bus_wr = 0; ev_w = 0; ev_b = 0; ev_a = 0;
    endtask

    task automatic wr(logic [15:0] d, logic [7:0] a = RA);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; step(); idle();
    endtask

    task automatic rd();
        bus_sel = 1; bus_wr = 0; bus_addr = RA; step(); idle();
    endtask

    task automatic clear_src();
        for (int b = 0; b < 5; b++) begin sf[b] = '0; se[b] = '0; end
    endtask

    initial begin
        clear_src();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset values while rst still high
        check("R9", bus_rdata, 16'h0, "rdata idle");
        bus_sel = 1; bus_addr = RA; #1;
        check("R9", bus_rdata, 16'h0, "reset word");
        check("R9", {8'h0, irq_req}, 16'h0, "reset irq");
        rst = 0; idle();
        m_en = '{default: 0}; m_evf = '{default: 0}; m_irq = '0;

        // R6: enables read/write
        cur_req = "R6"; wr(16'hA500); rd(); wr(16'h5A00); rd(); wr(16'h0000); rd();

        // R2: OR aggregation, walking one source per bank, own enable on
        cur_req = "R2";
        for (int b = 0; b < 5; b++)
            for (int k = 0; k < SRC_N; k++) begin
                clear_src(); sf[b][k] = 1; se[b][k] = 1; rd();
                se[b][k] = 0; rd();               // masked by own enable
                se[b] = ~(SRC_N'(1) << k); rd();  // other enables on, still masked
            end
        clear_src();

        // R7: line enable masks request; request follows one cycle later
        cur_req = "R7";
        sf[0] = 4'b0010; se[0] = 4'b0010; sf[4] = 4'b1000; se[4] = 4'b1000;
        rd(); rd();
        wr(16'h0100); rd(); rd();
        wr(16'hFF00); rd(); clear_src(); rd(); rd();

        // R3: writes to summary bits ignored
        cur_req = "R3";
        wr(16'hFFC7); rd(); sf[1] = 4'b0100; se[1] = 4'b0100; wr(16'hFF00); rd();
        clear_src(); rd();

        // R5 / R4: event set, write zero keeps, write one clears
        cur_req = "R5"; ev_w = 1; ev_b = 1; ev_a = 1; step(); idle(); rd();
        cur_req = "R4"; wr(16'hFF00); rd(); wr(16'hFF08); rd(); wr(16'hFF30); rd();
        cur_req = "R5"; ev_b = 1; bus_sel = 1; bus_wr = 1; bus_addr = RA; bus_wdata = 16'hFF38;
        step(); idle(); rd();
        cur_req = "R4"; wr(16'hFF10); rd();

        // R8: misaddressed writes and reads
        cur_req = "R8"; ev_a = 1; step(); idle();
        wr(16'h0020, 8'h17); rd(); wr(16'h0000, 8'h15); rd();
        bus_sel = 1; bus_wr = 0; bus_addr = 8'h40; step(); idle();
        bus_sel = 0; bus_wr = 0; bus_addr = RA; step();

        // R1: random traffic across all fields
        cur_req = "R1";
        for (int n = 0; n < 2000; n++) begin
            for (int b = 0; b < 5; b++) begin sf[b] = SRC_N'($urandom); se[b] = SRC_N'($urandom); end
            ev_w = ($urandom % 5) == 0; ev_b = ($urandom % 5) == 0; ev_a = ($urandom % 5) == 0;
            bus_sel = $urandom; bus_wr = $urandom;
            bus_addr = (($urandom % 4) == 0) ? 8'($urandom) : RA;
            bus_wdata = 16'($urandom);
            step();
        end
        idle();
        rd();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule